// File: doc/BRIEF.md
# Pipelined Parallel Majority-Logic Corrector

This block repairs a 15-bit word of a (15,7) cyclic code in one pass. Every bit position has its own group of four orthogonal parity check sums, its own majority vote and its own correction XOR, so the whole word is fixed at once without rotating it through a shift register. The code is built from the generator polynomial g(x) = 1 + x^4 + x^6 + x^7 + x^8, where bit j of the word holds the coefficient of x^j. The four check sums that vote on bit i are cyclic shifts of the parity set {0,1,3,7}. Each of them contains bit i, and no other bit appears in more than one of them.

A register stage holds the sixty check sums together with the raw word. A second stage holds the corrected word and a flag that is set when the word was not a valid codeword. A new word can enter on every clock cycle, and there is no stall path. The block sits on the read path of a protected memory. It corrects up to two flipped bits per word and flags any word that carries up to four flips.

Top module: `ml_parallel_corrector`

## Requirements
- R1: During synchronous active-low reset, and in the first cycle after it, `out_valid`, `out_word` and `out_err` are all zero.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles, with no gaps and no stalls.
- R3: A codeword of g(x) (bit j = coefficient of x^j) is passed through unchanged, with `out_err` = 0.
- R4: A codeword with one flipped bit, at any of the 15 positions, comes out as the original codeword, with `out_err` = 1.
- R5: A codeword with any two flipped bits comes out as the original codeword, with `out_err` = 1.
- R6: Words presented on consecutive cycles are each corrected separately. The result and the flag of one word never leak into another word.
- R7: `out_err` is 1 for any word that is not a codeword, including words with three or four flipped bits. A word whose output differs from its input always has `out_err` = 1.
- R8: When a cycle carries `in_valid` = 0, the matching output cycle keeps `out_word` and `out_err` at the values of the last valid word, whatever was driven on `in_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks `in_word` as a word to correct this cycle |
| in_word | input | 15 | Received word, bit j = coefficient of x^j |
| out_valid | output | 1 | Marks `out_word` and `out_err` as a fresh result |
| out_word | output | 15 | Corrected word |
| out_err | output | 1 | Set when the received word was not a codeword |

## Verification
The bench walks a single flip through every bit position and tries all 105 pairs of flips. This exposes a wrong tap in any check sum and a vote threshold set one too low or too high: a wrong tap either leaves a bit uncorrected or flips a good bit. Three- and four-flip words confirm that the flag cannot be fooled, which a flag built from only part of the check sums would miss. Back-to-back words with different error patterns, followed by idle cycles with junk on the input, catch a misaligned pipeline that pairs one word's flag with the next word's data. They also catch a result register that loads while no word is present.

// File: rtl/mlc_pkg.sv
// Shared constants and tap helpers for the parallel majority-logic corrector.
// Assumes the (15,7) cyclic code with generator 1+x^4+x^6+x^7+x^8, whose
// dual code is spanned by the cyclic shifts of the parity set {0,1,3,7}.
package mlc_pkg;

    localparam int unsigned CW_LEN  = 15;
    localparam int unsigned MSG_LEN = 7;
    localparam int unsigned CHK_NUM = 4;
    localparam int unsigned CHK_OFS [CHK_NUM] = '{0, 1, 3, 7};

    // Mask of the bits summed by check c of the group that votes on bit b.
    function automatic logic [CW_LEN-1:0] chk_mask(input int unsigned b, input int unsigned c);
        logic [CW_LEN-1:0] m;
        m = '0;
        for (int unsigned t = 0; t < CHK_NUM; t++) begin
            m[(b + CW_LEN - CHK_OFS[c] + CHK_OFS[t]) % CW_LEN] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/ml_checksum_stage.sv
// Stage one: forms the J orthogonal check sums for every bit position and
// registers them with the raw word. Data loads only on a valid cycle.
// Assumes the tap sets come from mlc_pkg::chk_mask.
module ml_checksum_stage #(
    parameter int unsigned N = mlc_pkg::CW_LEN,
    parameter int unsigned J = mlc_pkg::CHK_NUM
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [N-1:0]   in_word,
    output logic           s1_valid,
    output logic [N-1:0]   s1_word,
    output logic [N*J-1:0] s1_sums
);
    localparam int unsigned NSUM = N * J;

    logic [NSUM-1:0] sums_comb;

    // One XOR reduction per (bit, check) pair.
    for (genvar b = 0; b < N; b++) begin : g_bit
        for (genvar c = 0; c < J; c++) begin : g_chk
            localparam logic [N-1:0] TAPS = mlc_pkg::chk_mask(b, c);
            assign sums_comb[b*J + c] = ^(in_word & TAPS);
        end
    end

    // Stage-one pipeline register with valid tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_word  <= '0;
            s1_sums  <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_word <= in_word;
                s1_sums <= sums_comb;
            end
        end
    end

endmodule

// File: rtl/ml_majority_vote.sv
// Combinational majority gates: bit b is flipped when more than half of its
// J check sums are one. Also ORs all sums into a word-level error flag.
// Assumes sums are grouped J per bit, bit 0 lowest.
module ml_majority_vote #(
    parameter int unsigned N = mlc_pkg::CW_LEN,
    parameter int unsigned J = mlc_pkg::CHK_NUM
) (
    input  logic [N*J-1:0] sums,
    output logic [N-1:0]   flip,
    output logic           any_err
);
    localparam int unsigned CNT_W  = $clog2(J + 1);
    localparam int unsigned THRESH = J / 2 + 1;

    for (genvar b = 0; b < N; b++) begin : g_vote
        logic [CNT_W-1:0] ones;
        // Count ones among this bit's check sums and compare with the threshold.
        always_comb begin
            ones = '0;
            for (int unsigned t = 0; t < J; t++) begin
                ones = ones + CNT_W'(sums[b*J + t]);
            end
            flip[b] = (ones >= CNT_W'(THRESH));
        end
    end

    // Any nonzero check sum marks a word outside the code.
    assign any_err = |sums;

endmodule

// File: rtl/ml_correct_stage.sv
// Stage two: applies the majority decisions to the stored word and registers
// the result with the error flag. Holds its data when no word is present.
module ml_correct_stage #(
    parameter int unsigned N = mlc_pkg::CW_LEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s1_valid,
    input  logic [N-1:0] s1_word,
    input  logic [N-1:0] flip,
    input  logic         any_err,
    output logic         out_valid,
    output logic [N-1:0] out_word,
    output logic         out_err
);
    // Output register: corrected word and flag load on a valid stage-one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_word <= s1_word ^ flip;
                out_err  <= any_err;
            end
        end
    end

endmodule

// File: rtl/ml_parallel_corrector.sv
// Top: two-stage parallel one-step majority-logic corrector for the (15,7)
// cyclic code. Fixed two-cycle latency, one word per cycle, no backpressure.
module ml_parallel_corrector (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [14:0] in_word,
    output logic        out_valid,
    output logic [14:0] out_word,
    output logic        out_err
);
    localparam int unsigned N = mlc_pkg::CW_LEN;
    localparam int unsigned J = mlc_pkg::CHK_NUM;

    logic           s1_valid;
    logic [N-1:0]   s1_word;
    logic [N*J-1:0] s1_sums;
    logic [N-1:0]   flip;
    logic           any_err;

    ml_checksum_stage #(.N(N), .J(J)) u_sums (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_word  (in_word),
        .s1_valid (s1_valid),
        .s1_word  (s1_word),
        .s1_sums  (s1_sums)
    );

    ml_majority_vote #(.N(N), .J(J)) u_vote (
        .sums    (s1_sums),
        .flip    (flip),
        .any_err (any_err)
    );

    ml_correct_stage #(.N(N)) u_fix (
        .clk       (clk),
        .rst_n     (rst_n),
        .s1_valid  (s1_valid),
        .s1_word   (s1_word),
        .flip      (flip),
        .any_err   (any_err),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_err   (out_err)
    );

endmodule

// File: rtl/ml_parallel_corrector_chk.sv
// Port-level protocol checks for ml_parallel_corrector, attached by bind.
// Checks arm only once two post-reset edges have filled the pipeline.
module ml_parallel_corrector_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [14:0] in_word,
    input logic        out_valid,
    input logic [14:0] out_word,
    input logic        out_err
);
    logic [1:0] since_rst;
    logic       armed;

    // Count post-reset edges, saturating at three.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
    assign armed = (since_rst >= 2'd2);

    // R2: output valid is input valid two cycles late.
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid, 2)));

    // R3: a result without the flag equals the word that entered.
    p_clean_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid && !out_err) |-> (out_word == $past(in_word, 2)));

    // R7: any change applied to a word implies the flag.
    p_change_flagged_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && out_valid && (out_word != $past(in_word, 2))) |-> out_err);

    // R8: idle output cycles hold the previous result.
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !out_valid) |-> ($stable(out_word) && $stable(out_err)));

endmodule

bind ml_parallel_corrector ml_parallel_corrector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_err   (out_err)
);

// File: tb/sim_ml_parallel_corrector.sv
// Directed bench: each task drives one scenario through a two-deep model of
// expected results and checks every output cycle at the falling edge.
module sim_ml_parallel_corrector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [14:0] in_word = '0;
    logic        out_valid;
    logic [14:0] out_word;
    logic        out_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Expected-result pipeline, entry 1 = driven last cycle, entry 2 = two ago.
    logic        p1_v = 0, p2_v = 0, p1_e = 0, p2_e = 0, p1_k = 1, p2_k = 1;
    logic [14:0] p1_w = '0, p2_w = '0;
    string       p1_tag = "R1", p2_tag = "R1";
    logic [14:0] last_w = '0;
    logic        last_e = 1'b0;
    logic        last_k = 1'b1;

    always #10 clk = ~clk;

    ml_parallel_corrector u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_word   (in_word),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_err   (out_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [14:0] act, input logic [14:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Encoder in product form: message polynomial times g(x).
    function automatic logic [14:0] enc(input logic [6:0] msg);
        logic [14:0] c;
        c = '0;
        for (int j = 0; j < 7; j++)
            if (msg[j]) c ^= (15'b000_0001_1101_0001 << j);
        return c;
    endfunction

    task automatic check_out();
        chk(out_valid == p2_v, {p2_tag, " R2 valid"}, 15'(out_valid), 15'(p2_v));
        if (p2_v) begin
            if (p2_k) chk(out_word == p2_w, {p2_tag, " word"}, out_word, p2_w);
            chk(out_err == p2_e, {p2_tag, " flag"}, 15'(out_err), 15'(p2_e));
            last_w = p2_w; last_e = p2_e; last_k = p2_k;
        end else begin
            if (last_k) chk(out_word == last_w, "R8 hold word", out_word, last_w);
            chk(out_err == last_e, "R8 hold flag", 15'(out_err), 15'(last_e));
        end
    endtask

    // One cycle: check the result due now, then drive the next input.
    task automatic step(input logic v, input logic [14:0] w, input logic [14:0] ew,
                        input logic ee, input logic wk, input string tag);
        @(negedge clk);
        check_out();
        p2_v = p1_v; p2_w = p1_w; p2_e = p1_e; p2_k = p1_k; p2_tag = p1_tag;
        p1_v = v;    p1_w = ew;   p1_e = ee;   p1_k = wk;   p1_tag = tag;
        in_valid = v;
        in_word  = w;
    endtask

    task automatic flush();
        step(1'b0, 15'h0, 15'h0, 1'b0, 1'b1, "R2");
        step(1'b0, 15'h0, 15'h0, 1'b0, 1'b1, "R2");
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", 15'(out_valid), 15'h0);
        chk(out_word  == '0,   "R1 word",  out_word, 15'h0);
        chk(out_err   == 1'b0, "R1 flag",  15'(out_err), 15'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0 && out_word == '0 && out_err == 1'b0, "R1 after release",
            out_word, 15'h0);
    endtask

    task automatic t_clean();
        logic [6:0] msgs [5] = '{7'h00, 7'h7F, 7'h55, 7'h2A, 7'h13};
        for (int i = 0; i < 5; i++) step(1'b1, enc(msgs[i]), enc(msgs[i]), 1'b0, 1'b1, "R3");
        flush();
    endtask

    task automatic t_single();
        logic [6:0] msgs [3] = '{7'h00, 7'h4D, 7'h7F};
        for (int i = 0; i < 3; i++)
            for (int b = 0; b < 15; b++)
                step(1'b1, enc(msgs[i]) ^ (15'h1 << b), enc(msgs[i]), 1'b1, 1'b1, "R4");
        flush();
    endtask

    task automatic t_double();
        logic [14:0] c;
        c = enc(7'h5B);
        for (int a = 0; a < 15; a++)
            for (int b = a + 1; b < 15; b++)
                step(1'b1, c ^ (15'h1 << a) ^ (15'h1 << b), c, 1'b1, 1'b1, "R5");
        flush();
    endtask

    task automatic t_stream();
        for (int i = 0; i < 12; i++) begin
            logic [14:0] c;
            c = enc(7'(i * 11 + 3));
            if (i % 3 == 0)      step(1'b1, c, c, 1'b0, 1'b1, "R6");
            else if (i % 3 == 1) step(1'b1, c ^ (15'h1 << i), c, 1'b1, 1'b1, "R6");
            else                 step(1'b1, c ^ 15'h0041, c, 1'b1, 1'b1, "R6");
        end
        flush();
    endtask

    task automatic t_hold();
        logic [14:0] c;
        c = enc(7'h36);
        step(1'b1, c ^ 15'h0100, c, 1'b1, 1'b1, "R8");
        for (int i = 0; i < 4; i++) step(1'b0, 15'h5A5A ^ 15'(i), 15'h0, 1'b0, 1'b1, "R8");
        step(1'b1, c, c, 1'b0, 1'b1, "R8");
        for (int i = 0; i < 3; i++) step(1'b0, 15'h7FFF, 15'h0, 1'b0, 1'b1, "R8");
        flush();
    endtask

    task automatic t_heavy();
        logic [14:0] c;
        c = enc(7'h21);
        step(1'b1, c ^ 15'h0007, 15'h0, 1'b1, 1'b0, "R7");
        step(1'b1, c ^ 15'h2108, 15'h0, 1'b1, 1'b0, "R7");
        step(1'b1, c ^ 15'h4421, 15'h0, 1'b1, 1'b0, "R7");
        step(1'b1, c ^ 15'h0F00, 15'h0, 1'b1, 1'b0, "R7");
        step(1'b1, c, c, 1'b0, 1'b1, "R7");
        flush();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_clean();
        t_single();
        t_double();
        t_stream();
        t_hold();
        t_heavy();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 15'h0, 15'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule